// File: doc/BRIEF.md
# Dual-Port Quadrature Mouse Counter

This block tracks pointer motion on two controller ports. Each port has a horizontal and a vertical axis, and each axis is driven by a two-wire quadrature pair. The pairs do not reach the block directly. An external parallel-to-serial converter holds them, and the block reads that converter through a load strobe, a serial clock that the block generates, and one serial data line. Each frame is sixteen bits long. The first eight bits carry the four quadrature pairs. The last eight are general-purpose control inputs, which the block republishes as a byte.

Every axis is an 8-bit field. The two low bits show the live state of the pin pair, coded so that one step of the pair in the forward direction adds one to the whole field. The six upper bits therefore form a wrapping up/down motion counter. The same two low bits can also be read as digital joystick switches. Software reads one 16-bit word per port, with the vertical field in the upper byte. A test write loads the upper counter bits of all four axes at the same time.

Top module: `qmc_mouse_counter`

## Requirements
- R1: The word on `rd_data_o` is the register of the port chosen by `rd_sel_i` (0 = first port). Its bits 15:8 hold the vertical field and bits 7:0 hold the horizontal field. Within each field, bits 7:2 are the motion counter and bits 1:0 are the pin position.
- R2: Each frame opens with `ld_o` high for SCLK_HALF cycles. Then come 16 rising edges of `sclk_o`, each framed by SCLK_HALF low cycles and SCLK_HALF high cycles, so a frame lasts SCLK_HALF*33 cycles. `sdat_i` is sampled on each rising edge. `ld_o` and `sclk_o` are never high together.
- R3: Serial bit k (k = 0 is the first bit sampled) is assigned as follows. Bits 0/1 are the first port's horizontal pair (A, B). Bits 2/3 are the first port's vertical pair. Bits 4/5 are the second port's horizontal pair. Bits 6/7 are the second port's vertical pair.
- R4: After a frame, the low bits of a field are {A, A xor B} for its pair. Bit 1 therefore equals A, and bit 1 xor bit 0 equals B. For example, register bit 9 is the first signal of the vertical pair, and bit 9 xor bit 8 is its quadrature partner.
- R5: A forward step of the pair (A,B) through 00, 01, 11, 10, back to 00 adds one to the whole 8-bit field. A step from position 3 to position 0 carries into the counter.
- R6: A reverse step subtracts one from the field. The 6-bit counter wraps modulo 64 in both directions, with no saturation.
- R7: A change of two positions (00 to 11, 01 to 10, or the reverse) updates the low bits only and leaves the counter unchanged.
- R8: A cycle with `test_we_i` high loads `test_data_i[15:10]` into both vertical counters and `test_data_i[7:2]` into both horizontal counters. Bits 9:8 and 1:0 of the written word have no effect on any field.
- R9: `misc_o[i]` takes serial bit 8+i of the frame. It changes only when a frame completes.
- R10: The fields change only when a frame completes or on a test write. A frame that is still being shifted is never visible.
- R11: A synchronous reset clears all counters, pin positions and `misc_o` to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| sdat_i | input | 1 | Serial data from the external converter |
| test_we_i | input | 1 | Test write strobe that preloads all counters |
| test_data_i | input | 16 | Test write word |
| rd_sel_i | input | 1 | Port select for the read word |
| ld_o | output | 1 | Parallel-load strobe to the converter |
| sclk_o | output | 1 | Serial clock to the converter |
| rd_data_o | output | 16 | Selected port register |
| misc_o | output | 8 | Miscellaneous control byte from the frame tail |

## Verification
Any corruption of a counter or a pin position reaches `rd_data_o` within one cycle of the frame commit. It then persists, because later frames only add deltas to it. A bench that tracks every field independently therefore exposes a single wrong step at the next read. A serial timing fault, such as a wrong bit order or a missed edge, moves a pattern into the wrong field or into `misc_o` on the very first frame, one frame period after the load strobe. A leak of a partial frame appears as a register change in the middle of a frame, which a read taken halfway through the shift exposes.

// File: rtl/qmc_pkg.sv
package qmc_pkg;

    localparam int FIELD_W = 8;
    localparam int POS_W   = 2;
    localparam int CNT_W   = FIELD_W - POS_W;

    // One axis: wrapping motion counter above the live pin position.
    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic [POS_W-1:0] pos;
    } axis_field_t;

    typedef enum logic [1:0] {
        FS_LOAD = 2'd0,
        FS_LOW  = 2'd1,
        FS_HIGH = 2'd2
    } fe_state_t;

    typedef enum logic [1:0] {
        MV_HOLD = 2'd0,
        MV_UP   = 2'd1,
        MV_JUMP = 2'd2,
        MV_DOWN = 2'd3
    } move_t;

    // Gray pair (A,B) 00,01,11,10 maps to position 0,1,2,3.
    function automatic logic [POS_W-1:0] pair_to_pos(input logic a, input logic b);
        return {a, a ^ b};
    endfunction

    function automatic move_t classify(input logic [POS_W-1:0] old_pos,
                                       input logic [POS_W-1:0] new_pos);
        logic [POS_W-1:0] d;
        d = new_pos - old_pos;
        case (d)
            2'd1:    return MV_UP;
            2'd2:    return MV_JUMP;
            2'd3:    return MV_DOWN;
            default: return MV_HOLD;
        endcase
    endfunction

    function automatic axis_field_t step_field(input axis_field_t f,
                                               input logic [POS_W-1:0] new_pos);
        logic [FIELD_W-1:0] v;
        axis_field_t        r;
        v = f;
        case (classify(f.pos, new_pos))
            MV_UP:   r = axis_field_t'(v + FIELD_W'(1));
            MV_DOWN: r = axis_field_t'(v - FIELD_W'(1));
            default: begin
                r.cnt = f.cnt;
                r.pos = new_pos;
            end
        endcase
        return r;
    endfunction

endpackage

// File: rtl/qmc_serial_rx.sv
module qmc_serial_rx
    import qmc_pkg::*;
#(
    parameter int FRAME_BITS = 16,
    parameter int SCLK_HALF  = 2
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  sdat_i,
    output logic                  ld_o,
    output logic                  sclk_o,
    output logic                  frame_done_o,
    output logic [FRAME_BITS-1:0] frame_o
);

    localparam int HC_W = (SCLK_HALF > 1) ? $clog2(SCLK_HALF) : 1;
    localparam int BC_W = (FRAME_BITS > 1) ? $clog2(FRAME_BITS) : 1;
    localparam logic [HC_W-1:0] HC_LAST = HC_W'(SCLK_HALF - 1);
    localparam logic [BC_W-1:0] BC_LAST = BC_W'(FRAME_BITS - 1);

    fe_state_t             state;
    logic [HC_W-1:0]       hcnt;
    logic [BC_W-1:0]       bcnt;
    logic [FRAME_BITS-1:0] shreg;
    logic                  ld_r;
    logic                  sclk_r;
    logic                  done_r;
    logic                  phase_end;
    logic [FRAME_BITS-1:0] shreg_nxt;

    assign phase_end = (hcnt == HC_LAST);
    // First bit sampled ends up at bit 0 after FRAME_BITS shifts.
    assign shreg_nxt = {sdat_i, shreg[FRAME_BITS-1:1]};

    always_ff @(posedge clk) begin
        if (rst) begin
            state   <= FS_LOAD;
            hcnt    <= '0;
            bcnt    <= '0;
            shreg   <= '0;
            ld_r    <= 1'b1;
            sclk_r  <= 1'b0;
            done_r  <= 1'b0;
            frame_o <= '0;
        end else begin
            done_r <= 1'b0;
            hcnt   <= phase_end ? '0 : hcnt + HC_W'(1);
            case (state)
                FS_LOAD: begin
                    if (phase_end) begin
                        state <= FS_LOW;
                        ld_r  <= 1'b0;
                    end
                end
                FS_LOW: begin
                    if (phase_end) begin
                        state  <= FS_HIGH;
                        sclk_r <= 1'b1;
                        shreg  <= shreg_nxt;
                        if (bcnt == BC_LAST) begin
                            frame_o <= shreg_nxt;
                            done_r  <= 1'b1;
                        end
                    end
                end
                FS_HIGH: begin
                    if (phase_end) begin
                        sclk_r <= 1'b0;
                        if (bcnt == BC_LAST) begin
                            state <= FS_LOAD;
                            ld_r  <= 1'b1;
                            bcnt  <= '0;
                        end else begin
                            state <= FS_LOW;
                            bcnt  <= bcnt + BC_W'(1);
                        end
                    end
                end
                default: begin
                    state  <= FS_LOAD;
                    ld_r   <= 1'b1;
                    sclk_r <= 1'b0;
                    bcnt   <= '0;
                end
            endcase
        end
    end

    assign ld_o         = ld_r;
    assign sclk_o       = sclk_r;
    assign frame_done_o = done_r;

endmodule

// File: rtl/qmc_axis_counter.sv
module qmc_axis_counter
    import qmc_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             upd_i,
    input  logic             pin_a_i,
    input  logic             pin_b_i,
    input  logic             load_i,
    input  logic [CNT_W-1:0] load_val_i,
    output axis_field_t      field_o
);

    axis_field_t field_r;
    axis_field_t field_nxt;

    always_comb begin
        field_nxt = field_r;
        if (upd_i) begin
            field_nxt = step_field(field_r, pair_to_pos(pin_a_i, pin_b_i));
        end
        // Test preload owns the counter; the pin position keeps tracking.
        if (load_i) begin
            field_nxt.cnt = load_val_i;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            field_r <= '0;
        end else begin
            field_r <= field_nxt;
        end
    end

    assign field_o = field_r;

endmodule

// File: rtl/qmc_mouse_counter.sv
module qmc_mouse_counter
    import qmc_pkg::*;
#(
    parameter int PORTS     = 2,
    parameter int SCLK_HALF = 2,
    parameter int MISC_BITS = 8
) (
    input  logic                                clk,
    input  logic                                rst,
    input  logic                                sdat_i,
    input  logic                                test_we_i,
    input  logic [2*FIELD_W-1:0]                test_data_i,
    input  logic [((PORTS>1)?$clog2(PORTS):1)-1:0] rd_sel_i,
    output logic                                ld_o,
    output logic                                sclk_o,
    output logic [2*FIELD_W-1:0]                rd_data_o,
    output logic [MISC_BITS-1:0]                misc_o
);

    localparam int AXES       = 2 * PORTS;
    localparam int QUAD_BITS  = 2 * AXES;
    localparam int FRAME_BITS = QUAD_BITS + MISC_BITS;
    localparam int REG_W      = 2 * FIELD_W;

    logic                    frame_done;
    logic [FRAME_BITS-1:0]   frame_data;
    axis_field_t             fields [AXES];
    logic [AXES*FIELD_W-1:0] fields_flat;
    logic [REG_W-1:0]        port_reg [PORTS];
    logic [MISC_BITS-1:0]    misc_r;

    qmc_serial_rx #(
        .FRAME_BITS (FRAME_BITS),
        .SCLK_HALF  (SCLK_HALF)
    ) i_rx (
        .clk          (clk),
        .rst          (rst),
        .sdat_i       (sdat_i),
        .ld_o         (ld_o),
        .sclk_o       (sclk_o),
        .frame_done_o (frame_done),
        .frame_o      (frame_data)
    );

    // Axis g uses serial bits 2g (A) and 2g+1 (B); even g is horizontal.
    for (genvar g = 0; g < AXES; g++) begin : g_axis
        logic [CNT_W-1:0] preload;
        if ((g % 2) == 0) begin : g_horiz
            assign preload = test_data_i[FIELD_W-1:POS_W];
        end else begin : g_vert
            assign preload = test_data_i[REG_W-1:FIELD_W+POS_W];
        end

        qmc_axis_counter i_axis (
            .clk        (clk),
            .rst        (rst),
            .upd_i      (frame_done),
            .pin_a_i    (frame_data[2*g]),
            .pin_b_i    (frame_data[2*g+1]),
            .load_i     (test_we_i),
            .load_val_i (preload),
            .field_o    (fields[g])
        );

        assign fields_flat[g*FIELD_W +: FIELD_W] = fields[g];
    end

    for (genvar p = 0; p < PORTS; p++) begin : g_port
        assign port_reg[p] = {fields[2*p+1], fields[2*p]};
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            misc_r <= '0;
        end else if (frame_done) begin
            misc_r <= frame_data[FRAME_BITS-1:QUAD_BITS];
        end
    end

    assign rd_data_o = port_reg[rd_sel_i];
    assign misc_o    = misc_r;

endmodule

// File: rtl/qmc_mouse_counter_chk.sv
module qmc_mouse_counter_chk #(
    parameter int AXES      = 4,
    parameter int MISC_BITS = 8
) (
    input logic                  clk,
    input logic                  rst,
    input logic                  ld_o,
    input logic                  sclk_o,
    input logic                  test_we_i,
    input logic [15:0]           test_data_i,
    input logic [MISC_BITS-1:0]  misc_o,
    input logic                  frame_done,
    input logic [1:0]            frame_lo,
    input logic [AXES*8-1:0]     fields_flat
);

    // R2: strobe and serial clock never overlap
    a_r2_ld_sclk_excl: assert property (@(posedge clk) disable iff (rst)
        ld_o |-> !sclk_o);

    // R10: no field moves without a frame commit or a test write
    a_r10_hold_between_frames: assert property (@(posedge clk) disable iff (rst)
        (!frame_done && !test_we_i) |=> $stable(fields_flat));

    // R9: control byte changes only on a frame commit
    a_r9_misc_hold: assert property (@(posedge clk) disable iff (rst)
        !frame_done |=> $stable(misc_o));

    // R4: first horizontal field shows A and A^B of its pair
    a_r4_pin_state: assert property (@(posedge clk) disable iff (rst)
        frame_done |=> (fields_flat[1] == $past(frame_lo[0]))
                    && ((fields_flat[1] ^ fields_flat[0]) == $past(frame_lo[1])));

    // R5: forward step from position 0 adds one
    a_r5_forward: assert property (@(posedge clk) disable iff (rst)
        (frame_done && !test_we_i && fields_flat[1:0] == 2'b00 && frame_lo == 2'b10)
        |=> fields_flat[7:0] == $past(fields_flat[7:0]) + 8'd1);

    // R6: reverse step from position 0 subtracts one, wrapping
    a_r6_reverse: assert property (@(posedge clk) disable iff (rst)
        (frame_done && !test_we_i && fields_flat[1:0] == 2'b00 && frame_lo == 2'b01)
        |=> fields_flat[7:0] == $past(fields_flat[7:0]) - 8'd1);

    // R8: test write sets every counter, pin bits ignored
    a_r8_test_load: assert property (@(posedge clk) disable iff (rst)
        test_we_i |=> ({fields_flat[15:10], 2'b00, fields_flat[7:2], 2'b00}
                       == ($past(test_data_i) & 16'hFCFC))
                   && ({fields_flat[31:26], 2'b00, fields_flat[23:18], 2'b00}
                       == ($past(test_data_i) & 16'hFCFC)));

    // R11: reset clears all state
    a_r11_reset_clear: assert property (@(posedge clk)
        rst |=> (fields_flat == '0) && (misc_o == '0));

endmodule

bind qmc_mouse_counter qmc_mouse_counter_chk #(
    .AXES      (AXES),
    .MISC_BITS (MISC_BITS)
) i_chk (
    .clk         (clk),
    .rst         (rst),
    .ld_o        (ld_o),
    .sclk_o      (sclk_o),
    .test_we_i   (test_we_i),
    .test_data_i (test_data_i),
    .misc_o      (misc_o),
    .frame_done  (frame_done),
    .frame_lo    (frame_data[1:0]),
    .fields_flat (fields_flat)
);

// File: tb/test_qmc_mouse_counter.sv
module test_qmc_mouse_counter;

    localparam int HALF = 2;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        sdat;
    logic        test_we = 1'b0;
    logic [15:0] test_data = '0;
    logic [0:0]  rd_sel = 1'b0;
    logic        ld_o;
    logic        sclk_o;
    logic [15:0] rd_data;
    logic [7:0]  misc;

    int checks = 0;
    int errors = 0;
    bit done_flag = 0;

    always #2 clk = ~clk;

    qmc_mouse_counter #(.PORTS(2), .SCLK_HALF(HALF), .MISC_BITS(8)) i_qmc_mouse_counter (
        .clk         (clk),
        .rst         (rst),
        .sdat_i      (sdat),
        .test_we_i   (test_we),
        .test_data_i (test_data),
        .rd_sel_i    (rd_sel),
        .ld_o        (ld_o),
        .sclk_o      (sclk_o),
        .rd_data_o   (rd_data),
        .misc_o      (misc)
    );

    // External converter model: load on strobe rise, shift on clock fall.
    logic [15:0] cur_pat = '0;
    logic [15:0] conv_sh;
    logic        ld_q, sclk_q;
    always @(posedge clk) begin
        if (rst) begin
            conv_sh <= '0;
        end else if (ld_o && !ld_q) begin
            conv_sh <= cur_pat;
        end else if (sclk_q && !sclk_o) begin
            conv_sh <= conv_sh >> 1;
        end
        ld_q   <= ld_o;
        sclk_q <= sclk_o;
    end
    assign sdat = conv_sh[0];

    // Expected model, built from the requirements.
    logic [7:0] exp_f [4];
    logic [7:0] exp_misc;

    function automatic logic [7:0] model_step(input logic [7:0] old, input logic a, input logic b);
        logic [1:0] np;
        logic [1:0] d;
        case ({a, b})
            2'b00: np = 2'd0;
            2'b01: np = 2'd1;
            2'b11: np = 2'd2;
            default: np = 2'd3;
        endcase
        d = np - old[1:0];
        if (d == 2'd1) return old + 8'd1;
        if (d == 2'd3) return old - 8'd1;
        return {old[7:2], np};
    endfunction

    task automatic check(input string req, input string what,
                         input logic [31:0] got, input logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s %s: got %h expected %h", req, what, got, exp);
        end
    endtask

    task automatic read_port(input int p, output logic [15:0] v);
        rd_sel = p[0:0];
        #1;
        v = rd_data;
    endtask

    task automatic check_all(input string req);
        logic [15:0] v;
        read_port(0, v);
        check(req, "port0", {16'h0, v}, {16'h0, exp_f[1], exp_f[0]});
        read_port(1, v);
        check(req, "port1", {16'h0, v}, {16'h0, exp_f[3], exp_f[2]});
        check(req, "misc", {24'h0, misc}, {24'h0, exp_misc});
    endtask

    // One frame carrying pat, then a full comparison against the model.
    task automatic send(input logic [15:0] pat, input string req);
        @(posedge ld_o);
        cur_pat = pat;
        @(posedge ld_o);
        @(negedge clk);
        for (int g = 0; g < 4; g++) exp_f[g] = model_step(exp_f[g], pat[2*g], pat[2*g+1]);
        exp_misc = pat[15:8];
        check_all(req);
    endtask

    task automatic t_reset;
        for (int g = 0; g < 4; g++) exp_f[g] = 8'h00;
        exp_misc = 8'h00;
        check_all("R11");
    endtask

    task automatic t_serial;
        int rises = 0, ld_len = 1, overlap = 0, cyc = 1;
        logic prev_l = 1'b1, prev_s = 1'b0;
        @(posedge ld_o);
        @(negedge clk);
        for (int i = 0; i < 1000; i++) begin
            @(negedge clk);
            cyc++;
            if (ld_o && !prev_l) break;
            if (ld_o) ld_len++;
            if (sclk_o && !prev_s) rises++;
            if (ld_o && sclk_o) overlap++;
            prev_l = ld_o;
            prev_s = sclk_o;
        end
        check("R2", "sclk rises per frame", rises, 16);
        check("R2", "load strobe length", ld_len, HALF);
        check("R2", "frame period", cyc - 1, HALF * 33);
        check("R2", "strobe/clock overlap", overlap, 0);
    endtask

    task automatic t_forward;
        logic [15:0] v;
        send(16'h0002, "R5");
        send(16'h0003, "R5");
        send(16'h0001, "R5");
        send(16'h0000, "R5");
        read_port(0, v);
        check("R5", "carry into counter", {16'h0, v}, 32'h0004);
    endtask

    task automatic t_reverse;
        logic [15:0] v;
        send(16'h0001, "R6");
        send(16'h0003, "R6");
        send(16'h0002, "R6");
        send(16'h0000, "R6");
        send(16'h0001, "R6");
        read_port(0, v);
        check("R6", "wrap below zero", {16'h0, v}, 32'h00FF);
        send(16'h0000, "R6");
        read_port(0, v);
        check("R6", "wrap above max", {16'h0, v}, 32'h0000);
    endtask

    task automatic t_jump;
        logic [15:0] v;
        send(16'h0003, "R7");
        read_port(0, v);
        check("R7", "jump keeps counter", {16'h0, v}, 32'h0002);
        send(16'h0000, "R7");
    endtask

    task automatic t_order;
        logic [15:0] v;
        send(16'h0040, "R3");
        read_port(1, v);
        check("R3", "port1 vertical only", {16'h0, v}, 32'hFF00);
        read_port(0, v);
        check("R3", "port0 untouched", {16'h0, v}, 32'h0000);
        send(16'h0050, "R3");
        read_port(1, v);
        check("R1", "port1 both fields", {16'h0, v}, 32'hFFFF);
    endtask

    task automatic t_switch;
        logic [15:0] v;
        send(16'h000E, "R4");
        read_port(0, v);
        check("R4", "vertical A (bit9)", {31'h0, v[9]}, 32'h1);
        check("R4", "vertical B (bit9^bit8)", {31'h0, v[9] ^ v[8]}, 32'h1);
        check("R4", "horizontal A (bit1)", {31'h0, v[1]}, 32'h0);
        check("R4", "horizontal B (bit1^bit0)", {31'h0, v[1] ^ v[0]}, 32'h1);
    endtask

    task automatic t_misc_partial;
        logic [15:0] v;
        send(16'hA50E, "R9");
        @(posedge ld_o);
        cur_pat = 16'h3C0B;
        repeat (HALF * 16) @(negedge clk);
        read_port(0, v);
        check("R10", "mid-frame port0", {16'h0, v}, {16'h0, exp_f[1], exp_f[0]});
        check("R9", "mid-frame misc", {24'h0, misc}, 32'h00A5);
        @(posedge ld_o);
        @(negedge clk);
        for (int g = 0; g < 4; g++) exp_f[g] = model_step(exp_f[g], cur_pat[2*g], cur_pat[2*g+1]);
        exp_misc = 8'h3C;
        check_all("R10");
    endtask

    task automatic t_test_write;
        @(negedge clk);
        test_we   = 1'b1;
        test_data = 16'hAB57;
        @(negedge clk);
        test_we   = 1'b0;
        test_data = 16'h0000;
        exp_f[0] = {6'h15, exp_f[0][1:0]};
        exp_f[2] = {6'h15, exp_f[2][1:0]};
        exp_f[1] = {6'h2A, exp_f[1][1:0]};
        exp_f[3] = {6'h2A, exp_f[3][1:0]};
        check_all("R8");
        send(cur_pat, "R8");
    endtask

    task automatic t_reset_mid;
        send(16'h0000, "R11");
        @(negedge clk);
        rst = 1'b1;
        repeat (2) @(negedge clk);
        rst = 1'b0;
        t_reset();
        send(16'h0000, "R11");
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_serial();
        t_forward();
        t_reverse();
        t_jump();
        t_order();
        t_switch();
        t_misc_partial();
        t_test_write();
        t_reset_mid();
        if (!done_flag) begin
            done_flag = 1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done_flag) begin
            done_flag = 1;
            checks++;
            errors++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule